// File: doc/BRIEF.md
# Dual-Mode Host Bus Slave Interface

This block is the slave side of a word-wide host processor bus. A static mode pin chooses between two bus styles. In the first style, separate read and write strobes define each cycle. In the second style, a direction level and a data strobe define each cycle. Chip select and both strobes are brought into the core clock through two flip-flops. An access starts on the synchronised leading edge of the qualifying strobe.

For each access the block latches the word address, the direction and the write data. A space-select input then routes the access to one of two request/valid target ports: internal registers or external memory. The handshake output depends on the mode. In the first style it is a ready line that is driven only while the chip is selected. In the second style it is an acknowledge that is driven low, then driven high for one cycle, then released. The interrupt output is open-drain and is pulled low while an interrupt is pending.

Top module: `hostbus_if`

## Requirements
- R1: `mode_i` is captured while `rst_n` is low: 1 selects separate-strobe signalling and 0 selects direction-plus-data-strobe signalling. Changes to `mode_i` after reset have no effect.
- R2: While `cs_n_i` is high, no access is started: neither request port asserts. In separate-strobe mode, `rdy_oe_o` is 0 whenever `cs_n_i` is high.
- R3: In separate-strobe mode, `rd_n_i` low starts a read and `wr_n_i` low starts a write. In the other mode, `rd_n_i` is the active-low data strobe and `wr_n_i` is the direction: 1 means read, 0 means write.
- R4: `space_i` is sampled at the start of the access. A value of 1 routes the access to the `ext_*` port and 0 routes it to the `int_*` port. Only the selected request asserts.
- R5: The target address is the 20-bit word address `addr_i` (byte address bits 20..1). The request carries the write data and holds its address stable until the target's valid.
- R6: On a read, the captured target data appears on `data_o` with `data_oe_o` high while the handshake is asserted. `data_oe_o` stays high until one cycle after the synchronised strobe release. `data_oe_o` is never high on a write.
- R7: The handshake first becomes visible `wait_cfg_i`+2 clock cycles after the cycle in which the target's valid is high. `wait_cfg_i` is 0 to 7.
- R8: In separate-strobe mode, `rdy_oe_o` follows a low `cs_n_i`. `rdy_o` is 0 until the access completes and 1 while it is complete, until the strobe is released.
- R9: In the other mode, the acknowledge is released (`rdy_oe_o`=0) while idle. It is driven low on completion and held low until the strobe is released. It is then driven high for exactly one cycle and then released again.
- R10: `irq_oe_o` equals `irq_pend_i`, and the driven level `irq_o` is 0.
- R11: A request appears three clock edges after the strobe falls. A strobe held low starts only one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Bus style select, captured in reset |
| cs_n_i | input | 1 | Active-low chip select |
| wr_n_i | input | 1 | Write strobe or direction level |
| rd_n_i | input | 1 | Read strobe or data strobe |
| space_i | input | 1 | 1 = external memory, 0 = internal |
| addr_i | input | 20 | Word address (byte address bits 20..1) |
| data_i | input | 16 | Write data from the host |
| data_o | output | 16 | Read data to the host |
| data_oe_o | output | 1 | Data bus drive enable |
| rdy_o | output | 1 | Handshake level |
| rdy_oe_o | output | 1 | Handshake drive enable |
| wait_cfg_i | input | 3 | Extra wait cycles before the handshake |
| irq_pend_i | input | 1 | Interrupt pending |
| irq_o | output | 1 | Interrupt level (always low) |
| irq_oe_o | output | 1 | Interrupt drive enable |
| int_req_o | output | 1 | Internal target request |
| int_we_o | output | 1 | Internal target write |
| int_addr_o | output | 20 | Internal target word address |
| int_wdata_o | output | 16 | Internal target write data |
| int_rdata_i | input | 16 | Internal target read data |
| int_valid_i | input | 1 | Internal target completion |
| ext_req_o | output | 1 | External target request |
| ext_we_o | output | 1 | External target write |
| ext_addr_o | output | 20 | External target word address |
| ext_wdata_o | output | 16 | External target write data |
| ext_rdata_i | input | 16 | External target read data |
| ext_valid_i | input | 1 | External target completion |

## Verification
The assertions check the following on every cycle:
- the routing of a new request from the sampled space select;
- that requests and their addresses are held until valid;
- that no request starts while chip select is deasserted;
- that each request follows an active synchronised strobe;
- that the data drive turns on only as the wait phase ends;
- that the acknowledge is released only after it has been driven high.

The bench scenarios show the following:
- the exact handshake latency for each wait setting;
- the cycle at which the request appears;
- the correct read data on the bus;
- the timing of the release of the ready and data drive;
- that a late change of the mode pin is ignored.

// File: rtl/hostbus_if.sv
module hostbus_if #(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int WCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_i,
  input  logic           cs_n_i,
  input  logic           wr_n_i,
  input  logic           rd_n_i,
  input  logic           space_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  data_i,
  output logic [DW-1:0]  data_o,
  output logic           data_oe_o,
  output logic           rdy_o,
  output logic           rdy_oe_o,
  input  logic [WCW-1:0] wait_cfg_i,
  input  logic           irq_pend_i,
  output logic           irq_o,
  output logic           irq_oe_o,
  output logic           int_req_o,
  output logic           int_we_o,
  output logic [AW-1:0]  int_addr_o,
  output logic [DW-1:0]  int_wdata_o,
  input  logic [DW-1:0]  int_rdata_i,
  input  logic           int_valid_i,
  output logic           ext_req_o,
  output logic           ext_we_o,
  output logic [AW-1:0]  ext_addr_o,
  output logic [DW-1:0]  ext_wdata_o,
  input  logic [DW-1:0]  ext_rdata_i,
  input  logic           ext_valid_i
);

  typedef enum logic [2:0] {ST_IDLE, ST_ACCESS, ST_WAIT, ST_DONE, ST_REL} st_t;

  st_t            st;
  logic           mode_q;
  logic [2:0]     s1, s2;
  logic           strobe, strobe_q, rd_cyc, start;
  logic           space_q, we_q, rd_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic [WCW-1:0] cnt;
  logic           tgt_valid;
  logic [DW-1:0]  tgt_rdata;

  wire cs_s = s2[2];
  wire wr_s = s2[1];
  wire rd_s = s2[0];

  assign strobe    = !cs_s && (mode_q ? (!wr_s || !rd_s) : !rd_s);
  assign rd_cyc    = mode_q ? !rd_s : wr_s;
  assign start     = strobe && !strobe_q && (st == ST_IDLE);
  assign tgt_valid = space_q ? ext_valid_i : int_valid_i;
  assign tgt_rdata = space_q ? ext_rdata_i : int_rdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= mode_i;
      s1       <= '1;
      s2       <= '1;
      strobe_q <= 1'b0;
      st       <= ST_IDLE;
      cnt      <= '0;
      space_q  <= 1'b0;
      we_q     <= 1'b0;
      rd_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      s1       <= {cs_n_i, wr_n_i, rd_n_i};
      s2       <= s1;
      strobe_q <= strobe;
      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_ACCESS;
          space_q <= space_i;
          we_q    <= !rd_cyc;
          rd_q    <= rd_cyc;
          addr_q  <= addr_i;
          wdata_q <= data_i;
        end
        ST_ACCESS: if (tgt_valid) begin
          st      <= ST_WAIT;
          cnt     <= wait_cfg_i;
          rdata_q <= tgt_rdata;
        end
        ST_WAIT: begin
          if (cnt == '0) st <= ST_DONE;
          else           cnt <= cnt - 1'b1;
        end
        ST_DONE: if (!strobe) st <= ST_REL;
        ST_REL:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  wire req_on  = (st == ST_ACCESS);
  wire done_on = (st == ST_DONE);
  wire drv_on  = done_on || (st == ST_REL);

  assign int_req_o   = req_on && !space_q;
  assign ext_req_o   = req_on && space_q;
  assign int_we_o    = we_q;
  assign ext_we_o    = we_q;
  assign int_addr_o  = addr_q;
  assign ext_addr_o  = addr_q;
  assign int_wdata_o = wdata_q;
  assign ext_wdata_o = wdata_q;

  assign data_o    = rdata_q;
  assign data_oe_o = rd_q && drv_on;
  assign rdy_o     = mode_q ? done_on : !done_on;
  assign rdy_oe_o  = mode_q ? !cs_n_i : drv_on;
  assign irq_o     = 1'b0;
  assign irq_oe_o  = irq_pend_i;

  AST_ROUTE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_req_o) |-> $past(space_i)); // R4
  AST_ROUTE_INT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req_o) |-> !$past(space_i)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req_o && !int_valid_i) |=> int_req_o); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req_o && $past(ext_req_o)) |-> $stable(ext_addr_o)); // R5
  AST_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && st == ST_IDLE) |=> !(int_req_o || ext_req_o)); // R2
  AST_START_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req_o || ext_req_o) |-> $past(strobe)); // R11
  AST_DOE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> $past(st == ST_WAIT)); // R6
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && $fell(rdy_oe_o)) |-> $past(rdy_o)); // R9

endmodule

// File: tb/sim_hostbus_if.sv
`timescale 1ns/100ps
module sim_hostbus_if;
  localparam int AW = 20, DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, mode_i = 1'b1, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, space = 1'b0;
  logic [AW-1:0] addr_b = '0;
  logic [DW-1:0] data_b = '0, data_o;
  logic data_oe, rdy_o, rdy_oe, irq_o, irq_oe, irq_pend = 1'b0;
  logic [2:0] wait_cfg = '0;
  logic int_req, int_we, ext_req, ext_we;
  logic [AW-1:0] int_addr, ext_addr;
  logic [DW-1:0] int_wdata, ext_wdata, int_rdata, ext_rdata;
  logic int_valid = 1'b0, ext_valid = 1'b0;

  assign int_rdata = int_addr[15:0] ^ 16'h3C3C;
  assign ext_rdata = ext_addr[15:0] ^ 16'hA5A5;

  hostbus_if u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cs_n_i(cs_n), .wr_n_i(wr_n), .rd_n_i(rd_n),
    .space_i(space), .addr_i(addr_b), .data_i(data_b), .data_o(data_o), .data_oe_o(data_oe),
    .rdy_o(rdy_o), .rdy_oe_o(rdy_oe), .wait_cfg_i(wait_cfg), .irq_pend_i(irq_pend),
    .irq_o(irq_o), .irq_oe_o(irq_oe),
    .int_req_o(int_req), .int_we_o(int_we), .int_addr_o(int_addr), .int_wdata_o(int_wdata),
    .int_rdata_i(int_rdata), .int_valid_i(int_valid),
    .ext_req_o(ext_req), .ext_we_o(ext_we), .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata),
    .ext_rdata_i(ext_rdata), .ext_valid_i(ext_valid)
  );

  typedef struct packed {
    logic          ext;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } item_t;

  item_t exp_q[$];
  int checks = 0, fails = 0, cyc = 0, lat = 0, vcnt = 0, vcyc = 0;
  bit intel = 1'b1;
  logic prev_req = 1'b0;

  wire ack_w = intel ? (rdy_oe && rdy_o) : (rdy_oe && !rdy_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R11 watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // target model and scoreboard monitor
  always @(negedge clk) begin
    item_t e;
    logic cur;
    if (int_valid || ext_valid) begin
      int_valid = 1'b0;
      ext_valid = 1'b0;
    end else if (int_req || ext_req) begin
      if (vcnt >= lat) begin
        if (int_req) int_valid = 1'b1; else ext_valid = 1'b1;
        vcyc = cyc;
        vcnt = 0;
      end else vcnt++;
    end
    cur = int_req || ext_req;
    if (cur && !prev_req) begin
      if (exp_q.size() == 0) chk(1'b0, "R2", {31'd0, cur}, 32'd0);
      else begin
        e = exp_q.pop_front();
        chk(ext_req == e.ext, "R4", {31'd0, ext_req}, {31'd0, e.ext});
        chk((e.ext ? ext_we : int_we) == e.we, "R3", {31'd0, e.ext ? ext_we : int_we}, {31'd0, e.we});
        chk((e.ext ? ext_addr : int_addr) == e.addr, "R5", {12'd0, e.ext ? ext_addr : int_addr}, {12'd0, e.addr});
        if (e.we)
          chk((e.ext ? ext_wdata : int_wdata) == e.data, "R5", {16'd0, e.ext ? ext_wdata : int_wdata}, {16'd0, e.data});
      end
    end
    prev_req = cur;
  end

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0; mode_i = m; intel = m;
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mode_i = !m;  // R1: must be ignored
  endtask

  task automatic access(input bit we, input bit ext, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [2:0] cfg, input int l);
    int n;
    logic [DW-1:0] exp_rd;
    exp_rd = ext ? (a[15:0] ^ 16'hA5A5) : (a[15:0] ^ 16'h3C3C);
    lat = l; wait_cfg = cfg;
    exp_q.push_back('{ext: ext, we: we, addr: a, data: wd});
    @(negedge clk);
    addr_b = a; data_b = wd; space = ext; cs_n = 1'b0;
    if (intel) begin
      if (we) wr_n = 1'b0; else rd_n = 1'b0;
    end else begin
      wr_n = !we; rd_n = 1'b0;
    end
    repeat (2) @(negedge clk);
    chk(!(int_req || ext_req), "R11", {31'd0, int_req || ext_req}, 32'd0);
    if (intel) chk(rdy_oe && !rdy_o, "R8", {30'd0, rdy_oe, rdy_o}, 32'd2);
    else       chk(!rdy_oe, "R9", {31'd0, rdy_oe}, 32'd0);
    @(negedge clk);
    chk(int_req || ext_req, "R11", {31'd0, int_req || ext_req}, 32'd1);
    n = 0;
    while (!ack_w && n < 200) begin
      @(negedge clk);
      n++;
      if (we && data_oe) chk(1'b0, "R6", {31'd0, data_oe}, 32'd0);
    end
    chk(ack_w, "R7", {31'd0, ack_w}, 32'd1);
    chk((cyc - vcyc) == cfg + 2, "R7", cyc - vcyc, cfg + 2);
    if (!we) chk(data_oe && data_o == exp_rd, "R6", {15'd0, data_oe, data_o}, {15'd0, 1'b1, exp_rd});
    else     chk(!data_oe, "R6", {31'd0, data_oe}, 32'd0);
    repeat (2) @(negedge clk);
    chk(ack_w, intel ? "R8" : "R9", {31'd0, ack_w}, 32'd1);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    if (intel) begin
      #1;
      chk(!rdy_oe, "R8", {31'd0, rdy_oe}, 32'd0);
    end
    repeat (2) @(negedge clk);
    if (!intel) chk(rdy_oe && !rdy_o, "R9", {30'd0, rdy_oe, rdy_o}, 32'd2);
    @(negedge clk);
    chk(data_oe == !we, "R6", {31'd0, data_oe}, {31'd0, !we});
    if (!intel) chk(rdy_oe && rdy_o, "R9", {30'd0, rdy_oe, rdy_o}, 32'd3);
    @(negedge clk);
    chk(!data_oe, "R6", {31'd0, data_oe}, 32'd0);
    chk(!rdy_oe, intel ? "R8" : "R9", {31'd0, rdy_oe}, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_high_strobe();
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
    repeat (8) begin
      @(negedge clk);
      chk(!(int_req || ext_req), "R2", {31'd0, int_req || ext_req}, 32'd0);
    end
    if (intel) chk(!rdy_oe, "R2", {31'd0, rdy_oe}, 32'd0);
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    do_reset(1'b1);
    chk(!rdy_oe && !data_oe && !int_req && !ext_req, "R1", {28'd0, rdy_oe, data_oe, int_req, ext_req}, 32'd0);
    cs_n = 1'b0;
    #1;
    chk(rdy_oe && !rdy_o, "R1", {30'd0, rdy_oe, rdy_o}, 32'd2);
    cs_n = 1'b1;
    access(1'b1, 1'b0, 20'h00123, 16'hBEEF, 3'd0, 0);
    access(1'b0, 1'b0, 20'h0ABCD, 16'h0000, 3'd3, 1);
    access(1'b1, 1'b1, 20'hFFFFF, 16'h1234, 3'd7, 2);
    access(1'b0, 1'b1, 20'h80001, 16'h0000, 3'd1, 0);
    cs_high_strobe();
    irq_pend = 1'b1;
    #1;
    chk(irq_oe && !irq_o, "R10", {30'd0, irq_oe, irq_o}, 32'd2);
    irq_pend = 1'b0;
    #1;
    chk(!irq_oe, "R10", {31'd0, irq_oe}, 32'd0);

    do_reset(1'b0);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rdy_oe, "R1", {31'd0, rdy_oe}, 32'd0);
    cs_n = 1'b1;
    access(1'b1, 1'b1, 20'h54321, 16'hCAFE, 3'd2, 1);
    access(1'b0, 1'b1, 20'h0F0F0, 16'h0000, 3'd0, 3);
    access(1'b0, 1'b0, 20'h00002, 16'h0000, 3'd7, 0);
    access(1'b1, 1'b0, 20'h7FFFF, 16'hA55A, 3'd4, 0);
    cs_high_strobe();
    chk(exp_q.size() == 0, "R5", exp_q.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule